// File: doc/BRIEF.md
# Square-Wave Interrupt Output Generator

This block produces a software-programmed square wave on an interrupt output pin. The wave is derived from the block's own clock. Software writes a control word that carries a 16-bit tick count, a 3-bit mode selector and a diagnostic flag. When the mode selector holds the toggle code, the output level flips once every count+1 clock ticks. This gives a full period of 2*(count+1) ticks. Any other mode parks the output at 0. Because the period is an exact multiple of the clock, software can time the wave against a reference timer and work out the clock frequency from it.

A second register, the general control word, holds the bit that enables the pin driver. The live output level can always be read back as a status bit in the control word, whether the pin is enabled or not. Writing an all-zero control word puts the generator back into its power-on state. Any write to the control word restarts the tick count and clears the level, so every new setting starts from a known phase.

Top module: `sqw_irq_gen`

## Requirements
- R1: After reset the output level is 0, the control word reads 0, the general control word reads 0, and both `wave_out` and `wave_oe` are 0.
- R2: With mode field value 7 (toggle), the level first changes count+1 rising edges after the control write takes effect, then again every count+1 edges after that. The full period is 2*(count+1) edges.
- R3: With count 0 and the toggle mode, the level inverts on every rising edge.
- R4: With any mode value other than 7, the level stays at 0 and does not change.
- R5: Every write to the control word (`wr_sel` = 0) clears the level and restarts the tick count from zero, even if the new value matches the old one.
- R6: Writing an all-zero control word returns the generator to its power-on state: the control word reads back 0 and the level stays 0.
- R7: A control-word read (`rd_sel` = 0) returns count in bits 15:0, mode in bits 18:16, the diagnostic flag in bit 19 and the live level in bit 31. All other bits read 0, and bit 31 ignores written data.
- R8: `wave_oe` equals bit 0 of the general control word (`wr_sel`/`rd_sel` = 1). `wave_out` equals the level while that bit is 1 and is 0 while it is 0.
- R9: The level status bit in the control word keeps following the generator while the pin enable is 0.
- R10: The diagnostic flag is stored and read back, and it has no effect on the waveform.
- R11: A general-control read returns the enable in bit 0 and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock that also times the square wave |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe, sampled on the rising edge |
| wr_sel | input | 1 | Write target: 0 control word, 1 general control word |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read source: 0 control word, 1 general control word |
| rd_data | output | 32 | Combinational read data for the register picked by `rd_sel` |
| wave_out | output | 1 | Square-wave pin level, held at 0 while the pin is disabled |
| wave_oe | output | 1 | Pin output enable |

## Verification
A register write takes effect on the rising edge where `wr_en` is sampled high. From that edge the level is 0, and after k further edges it equals bit 0 of k/(count+1) in toggle mode, and 0 in any other mode. Read data and the pin are combinational from registered state, so each result can be checked in the same cycle it becomes valid. The bench drives inputs on falling edges and counts falling edges after the write edge. Each sample is compared against the value the formula predicts for exactly that many edges.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

    localparam int DATA_W    = 32;
    localparam int CNT_W     = 16;
    localparam int MODE_W    = 3;

    localparam int CNT_LSB   = 0;
    localparam int MODE_LSB  = CNT_LSB + CNT_W;
    localparam int DIAG_BIT  = MODE_LSB + MODE_W;
    localparam int LEVEL_BIT = DATA_W - 1;
    localparam int OE_BIT    = 0;

    localparam logic [MODE_W-1:0] MODE_TOGGLE = {MODE_W{1'b1}};

    typedef enum logic {
        SEL_CTRL = 1'b0,
        SEL_GEN  = 1'b1
    } sel_e;

    typedef struct packed {
        logic              diag;
        logic [MODE_W-1:0] mode;
        logic [CNT_W-1:0]  count;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] d);
        ctrl_t c;
        c.count = d[CNT_LSB +: CNT_W];
        c.mode  = d[MODE_LSB +: MODE_W];
        c.diag  = d[DIAG_BIT];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c, input logic lvl);
        logic [DATA_W-1:0] d;
        d = '0;
        d[CNT_LSB +: CNT_W]   = c.count;
        d[MODE_LSB +: MODE_W] = c.mode;
        d[DIAG_BIT]           = c.diag;
        d[LEVEL_BIT]          = lvl;
        return d;
    endfunction

    function automatic logic is_toggle(input logic [MODE_W-1:0] m);
        return m == MODE_TOGGLE;
    endfunction

endpackage

// File: rtl/sqw_regs.sv
module sqw_regs
    import sqw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl_q,
    output logic              oe_q,
    output logic              restart
);

    logic wr_ctrl;
    logic wr_gen;

    always_comb begin
        wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
        wr_gen  = wr_en && (wr_sel == SEL_GEN);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= unpack_ctrl(wr_data);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            oe_q <= 1'b0;
        end else if (wr_gen) begin
            oe_q <= wr_data[OE_BIT];
        end
    end

    assign restart = wr_ctrl;

endmodule

// File: rtl/sqw_tick.sv
module sqw_tick
    import sqw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic [CNT_W-1:0]  count,
    input  logic [MODE_W-1:0] mode,
    output logic [CNT_W-1:0]  tick_cnt,
    output logic              level
);

    logic run;
    logic wrap;

    always_comb begin
        run  = is_toggle(mode);
        wrap = (tick_cnt == count);
    end

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            tick_cnt <= '0;
            level    <= 1'b0;
        end else if (wrap) begin
            tick_cnt <= '0;
            level    <= ~level;
        end else begin
            tick_cnt <= tick_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sqw_pin.sv
module sqw_pin (
    input  logic level,
    input  logic oe,
    output logic pin_level,
    output logic pin_oe
);

    always_comb begin
        pin_oe    = oe;
        pin_level = oe & level;
    end

endmodule

// File: rtl/sqw_irq_gen.sv
module sqw_irq_gen
    import sqw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_sel,
    output logic [DATA_W-1:0] rd_data,
    output logic              wave_out,
    output logic              wave_oe
);

    ctrl_t            ctrl_q;
    logic             oe_q;
    logic             restart;
    logic [CNT_W-1:0] tick_cnt;
    logic             level;

    sqw_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .ctrl_q  (ctrl_q),
        .oe_q    (oe_q),
        .restart (restart)
    );

    sqw_tick u_tick (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .count    (ctrl_q.count),
        .mode     (ctrl_q.mode),
        .tick_cnt (tick_cnt),
        .level    (level)
    );

    sqw_pin u_pin (
        .level     (level),
        .oe        (oe_q),
        .pin_level (wave_out),
        .pin_oe    (wave_oe)
    );

    always_comb begin
        if (rd_sel == SEL_GEN) begin
            rd_data         = '0;
            rd_data[OE_BIT] = oe_q;
        end else begin
            rd_data = pack_ctrl(ctrl_q, level);
        end
    end

endmodule

// File: rtl/sqw_irq_gen_chk.sv
module sqw_irq_gen_chk
    import sqw_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [CNT_W-1:0]  count,
    input logic [MODE_W-1:0] mode,
    input logic [CNT_W-1:0]  tick_cnt,
    input logic              level,
    input logic              wave_out,
    input logic              wave_oe
);

    logic wr_ctrl;
    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);

    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        tick_cnt <= count);

    a_r2_wrap_toggle: assert property (@(posedge clk) disable iff (rst)
        (is_toggle(mode) && tick_cnt == count && !wr_ctrl) |=> (level != $past(level)));

    a_r2_hold_between: assert property (@(posedge clk) disable iff (rst)
        (is_toggle(mode) && tick_cnt != count && !wr_ctrl) |=> $stable(level));

    a_r4_idle_low: assert property (@(posedge clk) disable iff (rst)
        !is_toggle(mode) |-> !level);

    a_r5_write_clears: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (!level && tick_cnt == '0));

    a_r8_pin_gate: assert property (@(posedge clk) disable iff (rst)
        !wave_oe |-> !wave_out);

    a_r8_pin_follow: assert property (@(posedge clk) disable iff (rst)
        wave_oe |-> (wave_out == level));

endmodule

bind sqw_irq_gen sqw_irq_gen_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .count    (ctrl_q.count),
    .mode     (ctrl_q.mode),
    .tick_cnt (tick_cnt),
    .level    (level),
    .wave_out (wave_out),
    .wave_oe  (wave_oe)
);

// File: tb/sqw_irq_gen_test.sv
`timescale 1ns/1ps
module sqw_irq_gen_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [31:0] rd_data;
    logic        wave_out;
    logic        wave_oe;

    int total = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sqw_irq_gen uut (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_data  (wr_data),
        .rd_sel   (rd_sel),
        .rd_data  (rd_data),
        .wave_out (wave_out),
        .wave_oe  (wave_oe)
    );

    // Vector table: count, mode, expected half period in edges (0 = held low)
    localparam int NV = 7;
    localparam int VCOUNT [NV] = '{0, 1, 3, 9, 2, 4, 6};
    localparam int VMODE  [NV] = '{7, 7, 7, 7, 5, 0, 3};
    localparam int VHALF  [NV] = '{1, 2, 4, 10, 0, 0, 0};

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic sel, input logic [31:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    function automatic logic [31:0] ctrl_word(input int cnt, input int md, input bit dg);
        return (32'(dg) << 19) | (32'(md & 7) << 16) | 32'(cnt & 16'hffff);
    endfunction

    function automatic logic exp_level(input int half, input int k);
        if (half == 0) return 1'b0;
        return 1'((k / half) % 2);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_sel = 1'b0;
        check("R1 ctrl read", rd_data, 32'h0);
        rd_sel = 1'b1;
        check("R1 gen read", rd_data, 32'h0);
        check("R1 pin", {30'b0, wave_oe, wave_out}, 32'h0);

        // R11 general control read-back, enable on
        wr(1'b1, 32'hffff_ffff);
        rd_sel = 1'b1;
        check("R11 gen read", rd_data, 32'h1);
        check("R8 oe high", {31'b0, wave_oe}, 32'h1);
        rd_sel = 1'b0;

        // Vector loop: R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            int steps;
            wr(1'b0, ctrl_word(VCOUNT[v], VMODE[v], 1'b0));
            steps = (VHALF[v] == 0) ? 12 : 4 * VHALF[v];
            check(VCOUNT[v] == 0 ? "R3 start level" : "R2 start level",
                  {31'b0, wave_out}, 32'h0);
            for (int k = 1; k <= steps; k++) begin
                @(negedge clk);
                if (VHALF[v] == 0)
                    check("R4 held low", {31'b0, wave_out}, 32'h0);
                else if (VCOUNT[v] == 0)
                    check("R3 every tick", {31'b0, wave_out}, {31'b0, exp_level(VHALF[v], k)});
                else
                    check("R2 toggle", {31'b0, wave_out}, {31'b0, exp_level(VHALF[v], k)});
            end
        end

        // R7 / R10 field read-back with diag set; diag has no waveform effect
        wr(1'b0, ctrl_word(16'h1234 & 1, 7, 1'b1) | 32'h7ff0_0000);
        check("R7 fields", rd_data, ctrl_word(0, 7, 1'b1));
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R10 diag no effect", {31'b0, wave_out}, {31'b0, exp_level(1, k)});
        end
        wr(1'b0, ctrl_word(16'hbeef, 2, 1'b1));
        check("R7 wide count", rd_data, 32'h000a_beef);

        // R5 restart mid-wave
        wr(1'b0, ctrl_word(3, 7, 1'b0));
        repeat (5) @(negedge clk);
        check("R5 pre level", {31'b0, rd_data[31]}, 32'h1);
        wr(1'b0, ctrl_word(3, 7, 1'b0));
        check("R5 cleared", {31'b0, rd_data[31]}, 32'h0);
        repeat (3) @(negedge clk);
        check("R5 restart phase lo", {31'b0, rd_data[31]}, 32'h0);
        @(negedge clk);
        check("R5 restart phase hi", {31'b0, rd_data[31]}, 32'h1);

        // R8 / R9 disable pin; status keeps tracking
        wr(1'b1, 32'h0);
        check("R8 oe low", {30'b0, wave_oe, wave_out}, 32'h0);
        wr(1'b0, ctrl_word(0, 7, 1'b0));
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            check("R9 status", {31'b0, rd_data[31]}, {31'b0, exp_level(1, k)});
            check("R8 gated", {31'b0, wave_out}, 32'h0);
        end

        // R6 all-zero write
        wr(1'b0, 32'h0);
        check("R6 read zero", rd_data, 32'h0);
        repeat (5) @(negedge clk);
        check("R6 stays zero", rd_data, 32'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule